// File: doc/BRIEF.md
# UART Bypass Routing Switch

This block sits between the host-facing UART pins, the on-chip UART and a bank of general-purpose pins. While the chip is held in reset, every output it drives toward the host or the pin bank is released to high impedance, so other devices on the same serial lines can use them. Once reset is released, the host serial lines are wired straight to the internal UART. The core's own general-purpose pins pass through untouched.

A one-cycle bypass request changes the routing. The request is honoured only when the link layer reports that no radio links are open. When honoured, the four host serial signals go to a nibble of the general-purpose bank that leads to another device, and the internal UART sees idle lines. A deep-sleep request goes out to power management and stays high. Nothing but reset brings the normal routing back. A request that arrives while links are still open is dropped, and a one-cycle error pulse reports it.

All routing selects and enables come from flops, so enables move only on a clock edge. The bank width, the position of the bypass nibble and the idle level shown to the core are parameters.

Top module: `uart_bypass_switch`

## Requirements
- R1: While `rst_ni` is low, `uart_txd_oe_o`, `uart_rts_oe_o` and every bit of `gpio_oe_o` are 0. `sleep_req_o` and `bypass_err_o` are also 0.
- R2: From the first rising edge after reset release until bypass, both host output enables are 1. `uart_txd_o` follows `core_txd_i` and `uart_rts_o` follows `core_rts_i`. `core_rxd_o` follows `uart_rxd_i` and `core_cts_o` follows `uart_cts_i`.
- R3: In normal routing, each `gpio_o`/`gpio_oe_o` bit follows the same bit of `core_gpio_out_i`/`core_gpio_oe_i`. `core_gpio_in_o` always equals `gpio_i`.
- R4: If `bypass_req_i` and `links_idle_i` are both high at a rising edge in normal routing, bypass routing applies from that edge.
- R5: In bypass, with nibble lanes counted from bank bit `BYP_LSB`: lane 0 is an output carrying `uart_rxd_i` (host transmit), and lane 1 is an output carrying `uart_cts_i` (host request-to-send). Lanes 2 and 3 are inputs, so `gpio_oe_o` reads 0,0,1,1 from lane 3 down to lane 0. `uart_rts_o` carries lane 2 and `uart_txd_o` carries lane 3, with both host enables still 1.
- R6: In bypass, bank bits outside the nibble keep following the core as in R3.
- R7: In bypass, `core_rxd_o` and `core_cts_o` are held at `CORE_IDLE` (default 1).
- R8: `sleep_req_o` rises at the bypass-entry edge and stays high until reset.
- R9: A request at an edge where `links_idle_i` is low in normal routing leaves routing unchanged. It raises `bypass_err_o` for exactly the following cycle.
- R10: Requests in bypass have no effect and raise no error. Only reset restores normal routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bypass_req_i | input | 1 | One-cycle request to enter bypass |
| links_idle_i | input | 1 | High when no radio link is open |
| bypass_err_o | output | 1 | One-cycle pulse on a refused request |
| sleep_req_o | output | 1 | Deep-sleep request, sticky until reset |
| uart_rxd_i | input | 1 | Host transmit line into the chip |
| uart_cts_i | input | 1 | Host request-to-send into the chip |
| uart_txd_o | output | 1 | Serial data toward the host |
| uart_txd_oe_o | output | 1 | Output enable of `uart_txd_o` |
| uart_rts_o | output | 1 | Flow-control line toward the host |
| uart_rts_oe_o | output | 1 | Output enable of `uart_rts_o` |
| core_txd_i | input | 1 | Internal UART transmit data |
| core_rts_i | input | 1 | Internal UART flow-control output |
| core_rxd_o | output | 1 | Receive data to the internal UART |
| core_cts_o | output | 1 | Clear-to-send to the internal UART |
| core_gpio_out_i | input | GPIO_W | Core's pin output values |
| core_gpio_oe_i | input | GPIO_W | Core's pin output enables |
| core_gpio_in_o | output | GPIO_W | Pin levels returned to the core |
| gpio_i | input | GPIO_W | Pin bank input levels |
| gpio_o | output | GPIO_W | Pin bank output values |
| gpio_oe_o | output | GPIO_W | Pin bank output enables |

## Verification
The state that is hardest to reach from the ports is the moment when a refused request is followed by an accepted one, and then by further requests once bypass is active. Each of these depends on the exact combination of request and idle-flag values at particular edges. Random stimulus rarely produces them in a useful order. A directed sequence therefore drives them edge by edge. Repeated rounds of sparse random requests with a random idle flag then cover entry at arbitrary points, with reset asserted between rounds so that the sticky state is cleared and entered again.

// File: rtl/uart_byp_pkg.sv
`timescale 1ns/1ps
package uart_byp_pkg;
  localparam int unsigned NIB_W = 4;
  // lane order inside the bypass nibble is fixed by the far device's wiring
  localparam int unsigned LN_TX  = 0;
  localparam int unsigned LN_RTS = 1;
  localparam int unsigned LN_CTS = 2;
  localparam int unsigned LN_RX  = 3;

  typedef enum logic {LANE_IN = 1'b0, LANE_OUT = 1'b1} lane_dir_e;
  typedef enum logic {MODE_NORM = 1'b0, MODE_BYP = 1'b1} byp_mode_e;

  function automatic lane_dir_e lane_dir(input int unsigned lane);
    return (lane == LN_TX || lane == LN_RTS) ? LANE_OUT : LANE_IN;
  endfunction
endpackage

// File: rtl/uart_byp_ctrl.sv
`timescale 1ns/1ps
module uart_byp_ctrl
  import uart_byp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic idle_i,
  output logic live_o,
  output logic byp_o,
  output logic err_o
);
  byp_mode_e mode_q, mode_d;
  logic      live_q, err_q, err_d;

  always_comb begin
    mode_d = mode_q;
    err_d  = 1'b0;
    if (mode_q == MODE_NORM && req_i) begin
      if (idle_i) mode_d = MODE_BYP;
      else        err_d  = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_NORM;
      live_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      live_q <= 1'b1;
      err_q  <= err_d;
    end
  end

  assign live_o = live_q;
  assign byp_o  = (mode_q == MODE_BYP);
  assign err_o  = err_q;
endmodule

// File: rtl/uart_byp_lane.sv
`timescale 1ns/1ps
module uart_byp_lane
  import uart_byp_pkg::*;
#(
  parameter bit        IN_NIB = 1'b0,
  parameter lane_dir_e DIR    = LANE_IN
) (
  input  logic live_i,
  input  logic byp_i,
  input  logic core_out_i,
  input  logic core_oe_i,
  input  logic byp_out_i,
  output logic out_o,
  output logic oe_o
);
  generate
    if (IN_NIB) begin : g_nib
      localparam logic BYP_OE = (DIR == LANE_OUT);
      assign out_o = byp_i ? (BYP_OE & byp_out_i) : core_out_i;
      assign oe_o  = live_i & (byp_i ? BYP_OE : core_oe_i);
    end else begin : g_plain
      logic unused_byp;
      assign unused_byp = byp_i ^ byp_out_i;
      assign out_o = core_out_i;
      assign oe_o  = live_i & core_oe_i;
    end
  endgenerate
endmodule

// File: rtl/uart_byp_host_mux.sv
`timescale 1ns/1ps
module uart_byp_host_mux #(
  parameter logic CORE_IDLE = 1'b1
) (
  input  logic live_i,
  input  logic byp_i,
  input  logic core_txd_i,
  input  logic core_rts_i,
  input  logic far_rx_i,
  input  logic far_cts_i,
  input  logic uart_rxd_i,
  input  logic uart_cts_i,
  output logic uart_txd_o,
  output logic uart_txd_oe_o,
  output logic uart_rts_o,
  output logic uart_rts_oe_o,
  output logic core_rxd_o,
  output logic core_cts_o
);
  assign uart_txd_o    = byp_i ? far_rx_i  : core_txd_i;
  assign uart_rts_o    = byp_i ? far_cts_i : core_rts_i;
  assign uart_txd_oe_o = live_i;
  assign uart_rts_oe_o = live_i;
  assign core_rxd_o    = byp_i ? CORE_IDLE : uart_rxd_i;
  assign core_cts_o    = byp_i ? CORE_IDLE : uart_cts_i;
endmodule

// File: rtl/uart_bypass_switch.sv
`timescale 1ns/1ps
module uart_bypass_switch
  import uart_byp_pkg::*;
#(
  parameter int unsigned GPIO_W    = 6,
  parameter int unsigned BYP_LSB   = 2,
  parameter logic        CORE_IDLE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bypass_req_i,
  input  logic              links_idle_i,
  output logic              bypass_err_o,
  output logic              sleep_req_o,
  input  logic              uart_rxd_i,
  input  logic              uart_cts_i,
  output logic              uart_txd_o,
  output logic              uart_txd_oe_o,
  output logic              uart_rts_o,
  output logic              uart_rts_oe_o,
  input  logic              core_txd_i,
  input  logic              core_rts_i,
  output logic              core_rxd_o,
  output logic              core_cts_o,
  input  logic [GPIO_W-1:0] core_gpio_out_i,
  input  logic [GPIO_W-1:0] core_gpio_oe_i,
  output logic [GPIO_W-1:0] core_gpio_in_o,
  input  logic [GPIO_W-1:0] gpio_i,
  output logic [GPIO_W-1:0] gpio_o,
  output logic [GPIO_W-1:0] gpio_oe_o
);
  localparam int unsigned BYP_MSB = BYP_LSB + NIB_W - 1;

  logic live, byp;
  logic [NIB_W-1:0] nib_drive;

  uart_byp_ctrl u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (bypass_req_i),
    .idle_i (links_idle_i),
    .live_o (live),
    .byp_o  (byp),
    .err_o  (bypass_err_o)
  );

  assign sleep_req_o = byp;

  // host signals headed for the far device; input lanes drive nothing
  always_comb begin
    nib_drive         = '0;
    nib_drive[LN_TX]  = uart_rxd_i;
    nib_drive[LN_RTS] = uart_cts_i;
  end

  uart_byp_host_mux #(.CORE_IDLE(CORE_IDLE)) u_host (
    .live_i        (live),
    .byp_i         (byp),
    .core_txd_i    (core_txd_i),
    .core_rts_i    (core_rts_i),
    .far_rx_i      (gpio_i[BYP_LSB + LN_RX]),
    .far_cts_i     (gpio_i[BYP_LSB + LN_CTS]),
    .uart_rxd_i    (uart_rxd_i),
    .uart_cts_i    (uart_cts_i),
    .uart_txd_o    (uart_txd_o),
    .uart_txd_oe_o (uart_txd_oe_o),
    .uart_rts_o    (uart_rts_o),
    .uart_rts_oe_o (uart_rts_oe_o),
    .core_rxd_o    (core_rxd_o),
    .core_cts_o    (core_cts_o)
  );

  for (genvar i = 0; i < GPIO_W; i++) begin : g_pin
    localparam bit          IN_NIB = (i >= BYP_LSB) && (i <= BYP_MSB);
    localparam int unsigned LANE   = IN_NIB ? (i - BYP_LSB) : 0;
    uart_byp_lane #(
      .IN_NIB (IN_NIB),
      .DIR    (lane_dir(LANE))
    ) u_lane (
      .live_i     (live),
      .byp_i      (byp),
      .core_out_i (core_gpio_out_i[i]),
      .core_oe_i  (core_gpio_oe_i[i]),
      .byp_out_i  (nib_drive[LANE]),
      .out_o      (gpio_o[i]),
      .oe_o       (gpio_oe_o[i])
    );
  end

  assign core_gpio_in_o = gpio_i;
endmodule

// File: rtl/uart_bypass_chk.sv
`timescale 1ns/1ps
module uart_bypass_chk #(
  parameter int unsigned GPIO_W    = 6,
  parameter int unsigned BYP_LSB   = 2,
  parameter logic        CORE_IDLE = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bypass_req_i,
  input logic              links_idle_i,
  input logic              bypass_err_o,
  input logic              sleep_req_o,
  input logic              uart_txd_o,
  input logic              uart_txd_oe_o,
  input logic              uart_rts_oe_o,
  input logic              core_rxd_o,
  input logic              core_cts_o,
  input logic [GPIO_W-1:0] gpio_i,
  input logic [GPIO_W-1:0] gpio_oe_o
);
  // R1
  reset_hiz_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!uart_txd_oe_o && !uart_rts_oe_o && gpio_oe_o == '0 && !sleep_req_o));
  // R4
  enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bypass_req_i && links_idle_i) |=> sleep_req_o);
  // R8
  sleep_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_req_o |=> sleep_req_o);
  // R9
  err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_err_o |-> ($past(bypass_req_i && !links_idle_i) && !sleep_req_o));
  // R10
  no_err_in_byp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_req_o |=> !bypass_err_o);
  // R7
  core_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_req_o |-> (core_rxd_o == CORE_IDLE && core_cts_o == CORE_IDLE));
  // R5
  far_rx_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_req_o |-> (uart_txd_o == gpio_i[BYP_LSB + 3] && gpio_oe_o[BYP_LSB +: 4] == 4'b0011));
endmodule

bind uart_bypass_switch uart_bypass_chk #(
  .GPIO_W(GPIO_W), .BYP_LSB(BYP_LSB), .CORE_IDLE(CORE_IDLE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bypass_req_i(bypass_req_i),
  .links_idle_i(links_idle_i), .bypass_err_o(bypass_err_o),
  .sleep_req_o(sleep_req_o), .uart_txd_o(uart_txd_o),
  .uart_txd_oe_o(uart_txd_oe_o), .uart_rts_oe_o(uart_rts_oe_o),
  .core_rxd_o(core_rxd_o), .core_cts_o(core_cts_o),
  .gpio_i(gpio_i), .gpio_oe_o(gpio_oe_o)
);

// File: tb/sim_uart_bypass_switch.sv
`timescale 1ns/1ps
module sim_uart_bypass_switch;
  localparam int unsigned W   = 6;
  localparam int unsigned LSB = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic bypass_req_i = 0, links_idle_i = 0;
  logic bypass_err_o, sleep_req_o;
  logic uart_rxd_i = 1, uart_cts_i = 1;
  logic uart_txd_o, uart_txd_oe_o, uart_rts_o, uart_rts_oe_o;
  logic core_txd_i = 1, core_rts_i = 1;
  logic core_rxd_o, core_cts_o;
  logic [W-1:0] core_gpio_out_i = '0, core_gpio_oe_i = '0, gpio_i = '0;
  logic [W-1:0] core_gpio_in_o, gpio_o, gpio_oe_o;

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  // bench model state
  bit m_live = 0, m_byp = 0, m_err = 0;

  always #5 clk_i = ~clk_i;

  uart_bypass_switch #(.GPIO_W(W), .BYP_LSB(LSB), .CORE_IDLE(1'b1)) u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_oe(bit live, bit byp, logic [W-1:0] coe);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      if (!live) r[i] = 1'b0;
      else if (byp && i >= LSB && i < LSB + 4) r[i] = (i - LSB) < 2;
      else r[i] = coe[i];
    end
    return r;
  endfunction

  function automatic logic [W-1:0] exp_out(bit byp, logic [W-1:0] cout, logic rxd, logic cts);
    logic [W-1:0] r;
    r = cout;
    if (byp) begin
      r[LSB]   = rxd;
      r[LSB+1] = cts;
    end
    return r;
  endfunction

  task automatic check_all();
    logic [W-1:0] eoe;
    eoe = exp_oe(m_live, m_byp, core_gpio_oe_i);
    if (!rst_ni) begin
      chk("R1 host oe", {uart_txd_oe_o, uart_rts_oe_o}, 0);
      chk("R1 gpio oe", gpio_oe_o, 0);
      chk("R1 sleep/err", {sleep_req_o, bypass_err_o}, 0);
      return;
    end
    chk("R2 host oe", {uart_txd_oe_o, uart_rts_oe_o}, {m_live, m_live});
    chk("R8 sleep", sleep_req_o, m_byp);
    chk("R9 err", bypass_err_o, m_err);
    chk("R3 gpio in", core_gpio_in_o, gpio_i);
    chk(m_byp ? "R6 gpio oe" : "R3 gpio oe", gpio_oe_o, eoe);
    chk(m_byp ? "R5 gpio out" : "R3 gpio out", gpio_o & eoe,
        exp_out(m_byp, core_gpio_out_i, uart_rxd_i, uart_cts_i) & eoe);
    if (m_byp) begin
      chk("R5 host txd", uart_txd_o, gpio_i[LSB+3]);
      chk("R5 host rts", uart_rts_o, gpio_i[LSB+2]);
      chk("R7 core rx/cts", {core_rxd_o, core_cts_o}, 2'b11);
    end else begin
      chk("R2 host txd/rts", {uart_txd_o, uart_rts_o}, {core_txd_i, core_rts_i});
      chk("R2 core rx/cts", {core_rxd_o, core_cts_o}, {uart_rxd_i, uart_cts_i});
    end
  endtask

  task automatic step(input logic req, input logic idle);
    bypass_req_i    = req;
    links_idle_i    = idle;
    uart_rxd_i      = $urandom % 2;
    uart_cts_i      = $urandom % 2;
    core_txd_i      = $urandom % 2;
    core_rts_i      = $urandom % 2;
    core_gpio_out_i = W'($urandom);
    core_gpio_oe_i  = W'($urandom);
    gpio_i          = W'($urandom);
    #1 check_all();
    @(posedge clk_i);
    if (rst_ni) begin
      m_err  = !m_byp && req && !idle;
      if (!m_byp && req && idle) m_byp = 1;
      m_live = 1;
    end
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0;
    m_live = 0; m_byp = 0; m_err = 0;
    for (int k = 0; k < 3; k++) step($urandom % 2, $urandom % 2);
    rst_ni = 1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    do_reset();
    // first cycle after release: outputs still released until an edge (R2)
    step(0, 0);
    for (int k = 0; k < 4; k++) step(0, 1);
    // refused request, then accepted, then ignored ones (R9, R4, R10)
    step(1, 0);
    step(0, 1);
    step(1, 0);
    step(1, 1);
    for (int k = 0; k < 6; k++) step(1, k % 2);
    for (int k = 0; k < 20; k++) step(0, 1);
    // request on the very first edge after reset (R4)
    do_reset();
    step(1, 1);
    for (int k = 0; k < 8; k++) step($urandom % 2, $urandom % 2);
    // random rounds, reset clears the sticky state each time (R10)
    for (int r = 0; r < 10; r++) begin
      do_reset();
      for (int k = 0; k < 150; k++) step(($urandom % 24) == 0, ($urandom % 3) != 0);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule